// File: doc/BRIEF.md
# Video Format Standard Detector

This block watches the timing references of one video channel after word alignment and descrambling. Each end-of-active-video (EAV) and start-of-active-video (SAV) reference arrives as a single-cycle strobe with the vertical-blanking bit and the field bit that it carries. One word arrives per clock. From these strobes the block measures four things: the words in a line, the lines in a frame, the active lines in a frame, and whether the field bit was ever set during the frame. It maps that measurement to a 4-bit format code. Bit 3 of the code marks interlaced scan.

The code is never taken from a single frame. A new code is loaded only when two consecutive, regular frames give identical measurements. Otherwise the last code is kept. The valid flag goes high with the first code loaded after reset and then stays high.

The measured counts are compared against the nominal format constants, each divided (integer truncation) by the parameters `WORD_DIV` and `LINE_DIV`. Both default to 1, which gives the real rasters. A larger divisor lets a scaled-down raster exercise the same table.

Top module: `vfd_detect`

## Requirements
- R1: After reset the code is 0000 (750-line progressive) and the valid flag is 0.
- R2: Words per line is the number of clocks between successive EAV strobes. A frame starts at an EAV strobe whose V bit is 1 when the previous EAV had V=0 and whose F bit is 0. The lines of a frame are its EAV strobes. Its active lines are the SAV strobes with V=0. The frame counts as interlaced if any of its EAV strobes carries F=1.
- R3: A progressive frame with 750 lines and 1650 words gives 0000. A progressive frame with 1125 lines gives 0010 for 2200 words, 0100 for 2640 words and 0110 for 2750 words.
- R4: An interlaced frame with 1125 lines and 1080 active lines gives 1000 for 2200 words and 1010 for 2640 words.
- R5: An interlaced frame with 1250 lines and 2376 words gives 1100. An interlaced frame with 1125 lines, 2200 words and 1035 active lines gives 1110.
- R6: Any other progressive measurement gives 0111, and any other interlaced measurement gives 1111. The codes 0001, 0011, 0101, 1001, 1011 and 1101 never appear.
- R7: The code changes only when a completed regular frame matches the frame just before it in all four measurements. In every other case the previous code is held. The valid flag rises with the first such update and then remains 1.
- R8: A frame whose lines are not all the same length, or that has fewer than two lines, is irregular. An irregular frame never takes part in a match.
- R9: Whenever the code changes, its bit 3 equals the interlace measurement of the frame that caused the change.
- R10: Every count comparison uses the nominal value divided by `WORD_DIV` (words) or `LINE_DIV` (lines and active lines), with integer truncation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock, one word per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| eav_stb | input | 1 | End-of-active-video reference seen this word |
| sav_stb | input | 1 | Start-of-active-video reference seen this word |
| trs_v | input | 1 | Vertical blanking bit of the reference, valid with a strobe |
| trs_f | input | 1 | Field bit of the reference, valid with a strobe |
| fmt_code | output | 4 | Detected format code, bit 3 set for interlaced |
| fmt_valid | output | 1 | A code has been confirmed since reset |

## Verification
The hardest case to reach from the ports is a frame that is well formed on its own but never agrees with its neighbour. The alternating sequences reach it, and so do frames that carry one stretched line. In both cases the code must stay put through several completed frames. The stimulus gets there by running whole synthetic rasters, scaled by the divisors, frame after frame. It separates each scenario with a short irregular guard frame, so that the frame history returns to a known state. Between scenarios it inserts one-off frames of other formats, and it also stretches one line in every frame of a sequence. Random rasters, some on the nominal table and some off it, then cover the classification against a model in the bench.

// File: rtl/vfd_pkg.sv
// Shared constants for the video format detector: the format code table.
package vfd_pkg;
    typedef logic [3:0] fmt_code_t;

    // Progressive codes (bit 3 clear)
    localparam fmt_code_t FMT_P750_60   = 4'b0000;
    localparam fmt_code_t FMT_P1125_30  = 4'b0010;
    localparam fmt_code_t FMT_P1125_25  = 4'b0100;
    localparam fmt_code_t FMT_P1125_24  = 4'b0110;
    localparam fmt_code_t FMT_P_OTHER   = 4'b0111;
    // Interlaced codes (bit 3 set)
    localparam fmt_code_t FMT_I1125_30  = 4'b1000;
    localparam fmt_code_t FMT_I1125_25  = 4'b1010;
    localparam fmt_code_t FMT_I1250_25  = 4'b1100;
    localparam fmt_code_t FMT_I1035_30  = 4'b1110;
    localparam fmt_code_t FMT_I_OTHER   = 4'b1111;

    // Code held while no format has been confirmed
    localparam fmt_code_t FMT_RESET     = FMT_P750_60;
endpackage

// File: rtl/vfd_line_timer.sv
// Line timer: counts words since the last EAV strobe.
// Assumes one word per clock. line_len is the length of the line that the
// current EAV strobe closes, and it is valid in the cycle of that strobe.
// The count saturates, so an absent EAV cannot wrap into a plausible length.
module vfd_line_timer #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eav_stb,
    output logic [WORD_W-1:0] line_len
);
    localparam logic [WORD_W-1:0] CNT_MAX = '1;

    logic [WORD_W-1:0] since_eav;

    // Restart at every EAV; otherwise advance, saturating at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_eav <= '0;
        else if (eav_stb)
            since_eav <= '0;
        else if (since_eav != CNT_MAX)
            since_eav <= since_eav + 1'b1;
    end

    // The EAV word itself belongs to the line, so add one, with saturation.
    assign line_len = (since_eav == CNT_MAX) ? CNT_MAX : since_eav + 1'b1;
endmodule

// File: rtl/vfd_frame_meter.sv
// Frame meter: finds frame starts and gathers the per-frame measurement.
// Assumes EAV and SAV strobes do not coincide, and that V and F are valid
// together with a strobe. A frame starts at an EAV with V=1 and F=0 when
// the previous EAV had V=0. The measurement of the frame that just ended is
// published for one cycle through frame_done.
module vfd_frame_meter #(
    parameter int WORD_W = 12,
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eav_stb,
    input  logic              sav_stb,
    input  logic              trs_v,
    input  logic              trs_f,
    input  logic [WORD_W-1:0] line_len,
    output logic              frame_done,
    output logic [WORD_W-1:0] m_words,
    output logic [LINE_W-1:0] m_lines,
    output logic [LINE_W-1:0] m_active,
    output logic              m_ilace,
    output logic              m_regular
);
    localparam logic [LINE_W-1:0] LINE_MAX = '1;

    logic              prev_v;
    logic              armed;
    logic [LINE_W-1:0] line_cnt;
    logic [LINE_W-1:0] act_cnt;
    logic              saw_f;
    logic [WORD_W-1:0] ref_len;
    logic              ref_ok;
    logic              irregular;
    logic              frame_start;
    logic              len_bad;

    assign frame_start = eav_stb && trs_v && !prev_v && !trs_f;
    assign len_bad     = ref_ok && (line_len != ref_len);

    // Remember the V bit of the latest EAV, for the frame start test.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_v <= 1'b0;
        else if (eav_stb)
            prev_v <= trs_v;
    end

    // Arm at the first frame start, so no partial frame is ever published.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (frame_start)
            armed <= 1'b1;
    end

    // Count lines (EAVs) and note the field bit within the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_cnt <= '0;
            saw_f    <= 1'b0;
        end else if (frame_start) begin
            line_cnt <= LINE_W'(1);
            saw_f    <= 1'b0;
        end else if (eav_stb) begin
            if (line_cnt != LINE_MAX)
                line_cnt <= line_cnt + 1'b1;
            if (trs_f)
                saw_f <= 1'b1;
        end
    end

    // Count active lines as SAV strobes outside vertical blanking.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_cnt <= '0;
        else if (frame_start)
            act_cnt <= '0;
        else if (sav_stb && !trs_v && act_cnt != LINE_MAX)
            act_cnt <= act_cnt + 1'b1;
    end

    // Take the first line length as the reference and flag any line that differs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_len   <= '0;
            ref_ok    <= 1'b0;
            irregular <= 1'b0;
        end else if (frame_start) begin
            ref_ok    <= 1'b0;
            irregular <= 1'b0;
        end else if (eav_stb) begin
            if (!ref_ok) begin
                ref_len <= line_len;
                ref_ok  <= 1'b1;
            end else if (len_bad) begin
                irregular <= 1'b1;
            end
        end
    end

    // Publish the finished frame's measurement at the next frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_done <= 1'b0;
            m_words    <= '0;
            m_lines    <= '0;
            m_active   <= '0;
            m_ilace    <= 1'b0;
            m_regular  <= 1'b0;
        end else begin
            frame_done <= frame_start && armed;
            if (frame_start && armed) begin
                m_words   <= ref_len;
                m_lines   <= line_cnt;
                m_active  <= act_cnt;
                m_ilace   <= saw_f;
                m_regular <= ref_ok && !irregular && !len_bad;
            end
        end
    end
endmodule

// File: rtl/vfd_classifier.sv
// Classifier: maps one frame measurement onto the format code table.
// Purely combinational. Nominal counts are divided by WORD_DIV / LINE_DIV
// (truncating) so that a scaled raster can exercise the same table.
module vfd_classifier
    import vfd_pkg::*;
#(
    parameter int WORD_W   = 12,
    parameter int LINE_W   = 11,
    parameter int WORD_DIV = 1,
    parameter int LINE_DIV = 1
) (
    input  logic [WORD_W-1:0] m_words,
    input  logic [LINE_W-1:0] m_lines,
    input  logic [LINE_W-1:0] m_active,
    input  logic              m_ilace,
    output fmt_code_t         class_code
);
    localparam logic [WORD_W-1:0] W_1650 = WORD_W'(1650 / WORD_DIV);
    localparam logic [WORD_W-1:0] W_2200 = WORD_W'(2200 / WORD_DIV);
    localparam logic [WORD_W-1:0] W_2640 = WORD_W'(2640 / WORD_DIV);
    localparam logic [WORD_W-1:0] W_2750 = WORD_W'(2750 / WORD_DIV);
    localparam logic [WORD_W-1:0] W_2376 = WORD_W'(2376 / WORD_DIV);
    localparam logic [LINE_W-1:0] L_750  = LINE_W'(750  / LINE_DIV);
    localparam logic [LINE_W-1:0] L_1125 = LINE_W'(1125 / LINE_DIV);
    localparam logic [LINE_W-1:0] L_1250 = LINE_W'(1250 / LINE_DIV);
    localparam logic [LINE_W-1:0] A_1080 = LINE_W'(1080 / LINE_DIV);
    localparam logic [LINE_W-1:0] A_1035 = LINE_W'(1035 / LINE_DIV);

    logic is_l750, is_l1125, is_l1250, is_a1080, is_a1035;
    logic is_w1650, is_w2200, is_w2640, is_w2750, is_w2376;

    assign is_l750  = (m_lines  == L_750);
    assign is_l1125 = (m_lines  == L_1125);
    assign is_l1250 = (m_lines  == L_1250);
    assign is_a1080 = (m_active == A_1080);
    assign is_a1035 = (m_active == A_1035);
    assign is_w1650 = (m_words  == W_1650);
    assign is_w2200 = (m_words  == W_2200);
    assign is_w2640 = (m_words  == W_2640);
    assign is_w2750 = (m_words  == W_2750);
    assign is_w2376 = (m_words  == W_2376);

    // Choose the table entry; unmatched measurements fall to the unknown codes.
    always_comb begin
        if (!m_ilace) begin
            class_code = FMT_P_OTHER;
            if (is_l750 && is_w1650)
                class_code = FMT_P750_60;
            else if (is_l1125 && is_w2200)
                class_code = FMT_P1125_30;
            else if (is_l1125 && is_w2640)
                class_code = FMT_P1125_25;
            else if (is_l1125 && is_w2750)
                class_code = FMT_P1125_24;
        end else begin
            class_code = FMT_I_OTHER;
            if (is_l1125 && is_a1080 && is_w2200)
                class_code = FMT_I1125_30;
            else if (is_l1125 && is_a1080 && is_w2640)
                class_code = FMT_I1125_25;
            else if (is_l1250 && is_w2376)
                class_code = FMT_I1250_25;
            else if (is_l1125 && is_a1035 && is_w2200)
                class_code = FMT_I1035_30;
        end
    end
endmodule

// File: rtl/vfd_code_reg.sv
// Code register: confirms a format only when two consecutive regular frames
// agree exactly, and otherwise holds the previous code.
// Assumes the measurement inputs are stable while frame_done is low.
module vfd_code_reg
    import vfd_pkg::*;
#(
    parameter int WORD_W = 12,
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic [WORD_W-1:0] m_words,
    input  logic [LINE_W-1:0] m_lines,
    input  logic [LINE_W-1:0] m_active,
    input  logic              m_ilace,
    input  logic              m_regular,
    input  fmt_code_t         class_code,
    output fmt_code_t         fmt_code,
    output logic              fmt_valid
);
    logic [WORD_W-1:0] h_words;
    logic [LINE_W-1:0] h_lines;
    logic [LINE_W-1:0] h_active;
    logic              h_ilace;
    logic              h_ok;
    logic              agree;

    assign agree = h_ok && m_regular &&
                   (m_words == h_words) && (m_lines == h_lines) &&
                   (m_active == h_active) && (m_ilace == h_ilace);

    // Keep the previous frame's measurement for the next comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_words  <= '0;
            h_lines  <= '0;
            h_active <= '0;
            h_ilace  <= 1'b0;
            h_ok     <= 1'b0;
        end else if (frame_done) begin
            h_words  <= m_words;
            h_lines  <= m_lines;
            h_active <= m_active;
            h_ilace  <= m_ilace;
            h_ok     <= m_regular;
        end
    end

    // Load the classified code only when two frames in a row agree.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_code  <= FMT_RESET;
            fmt_valid <= 1'b0;
        end else if (frame_done && agree) begin
            fmt_code  <= class_code;
            fmt_valid <= 1'b1;
        end
    end
endmodule

// File: rtl/vfd_detect.sv
// Video format detector top: line timer -> frame meter -> classifier ->
// code register. Assumes aligned, decoded references of one channel,
// one word per clock, with a single-cycle strobe for each EAV and SAV.
module vfd_detect
    import vfd_pkg::*;
#(
    parameter int WORD_W   = 12,
    parameter int LINE_W   = 11,
    parameter int WORD_DIV = 1,
    parameter int LINE_DIV = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       eav_stb,
    input  logic       sav_stb,
    input  logic       trs_v,
    input  logic       trs_f,
    output logic [3:0] fmt_code,
    output logic       fmt_valid
);
    logic [WORD_W-1:0] line_len;
    logic              frame_done;
    logic [WORD_W-1:0] m_words;
    logic [LINE_W-1:0] m_lines;
    logic [LINE_W-1:0] m_active;
    logic              m_ilace;
    logic              m_regular;
    fmt_code_t         class_code;

    vfd_line_timer #(.WORD_W(WORD_W)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .eav_stb  (eav_stb),
        .line_len (line_len)
    );

    vfd_frame_meter #(.WORD_W(WORD_W), .LINE_W(LINE_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .eav_stb    (eav_stb),
        .sav_stb    (sav_stb),
        .trs_v      (trs_v),
        .trs_f      (trs_f),
        .line_len   (line_len),
        .frame_done (frame_done),
        .m_words    (m_words),
        .m_lines    (m_lines),
        .m_active   (m_active),
        .m_ilace    (m_ilace),
        .m_regular  (m_regular)
    );

    vfd_classifier #(
        .WORD_W(WORD_W), .LINE_W(LINE_W),
        .WORD_DIV(WORD_DIV), .LINE_DIV(LINE_DIV)
    ) u_class (
        .m_words    (m_words),
        .m_lines    (m_lines),
        .m_active   (m_active),
        .m_ilace    (m_ilace),
        .class_code (class_code)
    );

    vfd_code_reg #(.WORD_W(WORD_W), .LINE_W(LINE_W)) u_code (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .m_words    (m_words),
        .m_lines    (m_lines),
        .m_active   (m_active),
        .m_ilace    (m_ilace),
        .m_regular  (m_regular),
        .class_code (class_code),
        .fmt_code   (fmt_code),
        .fmt_valid  (fmt_valid)
    );
endmodule

// File: rtl/vfd_checks.sv
// Assertion checker for vfd_detect, attached by bind below.
// Relates the published frame measurement to the code outputs over time.
module vfd_checks (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] fmt_code,
    input logic       fmt_valid,
    input logic       frame_done,
    input logic       meas_ilace
);
    // R1: on the first cycle out of reset the reset code and valid=0 are shown
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (fmt_code == 4'b0000 && !fmt_valid));

    // R7: without a finished frame the code does not move
    a_r7_hold_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(fmt_code));

    // R7: once confirmed, valid stays high
    a_r7_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_valid |=> fmt_valid);

    // R6: reserved odd codes never appear
    a_r6_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        !(fmt_code[0] && fmt_code[2:1] != 2'b11));

    // R9: a code change carries the interlace bit of the frame behind it
    a_r9_interlace_bit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fmt_code) |-> (fmt_code[3] == $past(meas_ilace)));
endmodule

bind vfd_detect vfd_checks u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fmt_code   (fmt_code),
    .fmt_valid  (fmt_valid),
    .frame_done (frame_done),
    .meas_ilace (m_ilace)
);

// File: tb/sim_vfd_detect.sv
// Bench for vfd_detect: scaled rasters (words/100, lines/25), directed
// formats and hold cases, then random rasters checked against a model.
module sim_vfd_detect;
    localparam int CLK_PERIOD = 10;
    localparam int WDIV = 100;
    localparam int LDIV = 25;
    localparam int WATCHDOG = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       eav_stb = 1'b0;
    logic       sav_stb = 1'b0;
    logic       trs_v = 1'b0;
    logic       trs_f = 1'b0;
    logic [3:0] fmt_code;
    logic       fmt_valid;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vfd_detect #(.WORD_DIV(WDIV), .LINE_DIV(LDIV)) u0 (
        .clk(clk), .rst_n(rst_n), .eav_stb(eav_stb), .sav_stb(sav_stb),
        .trs_v(trs_v), .trs_f(trs_f), .fmt_code(fmt_code), .fmt_valid(fmt_valid)
    );

    task automatic check(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Model of R3-R6 and R10
    function automatic logic [3:0] model(input int lines, input int words, input int act, input bit il);
        if (!il) begin
            if (lines == 750/LDIV && words == 1650/WDIV) return 4'b0000;
            if (lines == 1125/LDIV && words == 2200/WDIV) return 4'b0010;
            if (lines == 1125/LDIV && words == 2640/WDIV) return 4'b0100;
            if (lines == 1125/LDIV && words == 2750/WDIV) return 4'b0110;
            return 4'b0111;
        end
        if (lines == 1125/LDIV && act == 1080/LDIV && words == 2200/WDIV) return 4'b1000;
        if (lines == 1125/LDIV && act == 1080/LDIV && words == 2640/WDIV) return 4'b1010;
        if (lines == 1250/LDIV && words == 2376/WDIV) return 4'b1100;
        if (lines == 1125/LDIV && act == 1035/LDIV && words == 2200/WDIV) return 4'b1110;
        return 4'b1111;
    endfunction

    task automatic send_line(input int w, input bit v, input bit f);
        for (int c = 0; c < w; c++) begin
            @(negedge clk);
            eav_stb = (c == 0);
            sav_stb = (c == 2);
            trs_v = v;
            trs_f = f;
        end
    endtask

    // Blanking lines lead each field; bad >= 0 stretches that line by one word.
    task automatic send_frame(input int lines, input int words, input int act, input bit il, input int bad);
        int blanks = lines - act;
        int b1 = blanks / 2;
        int n1 = b1 + act / 2;
        for (int li = 0; li < lines; li++) begin
            int w = words + ((li == bad) ? 1 : 0);
            if (!il)
                send_line(w, li < blanks, 1'b0);
            else if (li < n1)
                send_line(w, li < b1, 1'b0);
            else
                send_line(w, (li - n1) < (blanks - b1), 1'b1);
        end
    endtask

    // Short irregular guard frame: closes the last frame, clears the history.
    task automatic kick();
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            eav_stb = (c == 0 || c == 3 || c == 8);
            sav_stb = 1'b0;
            trs_v = (c < 3);
            trs_f = 1'b0;
        end
    endtask

    task automatic fmt_of(input int idx, output int l, output int w, output int a, output bit il, output logic [3:0] code);
        case (idx)
            0: begin l = 750/LDIV;  w = 1650/WDIV; a = 720/LDIV;  il = 0; code = 4'b0000; end
            1: begin l = 1125/LDIV; w = 2200/WDIV; a = 1080/LDIV; il = 0; code = 4'b0010; end
            2: begin l = 1125/LDIV; w = 2640/WDIV; a = 1080/LDIV; il = 0; code = 4'b0100; end
            3: begin l = 1125/LDIV; w = 2750/WDIV; a = 1080/LDIV; il = 0; code = 4'b0110; end
            4: begin l = 1125/LDIV; w = 2200/WDIV; a = 1080/LDIV; il = 1; code = 4'b1000; end
            5: begin l = 1125/LDIV; w = 2640/WDIV; a = 1080/LDIV; il = 1; code = 4'b1010; end
            6: begin l = 1250/LDIV; w = 2376/WDIV; a = 1080/LDIV; il = 1; code = 4'b1100; end
            default: begin l = 1125/LDIV; w = 2200/WDIV; a = 1035/LDIV; il = 1; code = 4'b1110; end
        endcase
    endtask

    task automatic establish(input int l, input int w, input int a, input bit il);
        send_frame(l, w, a, il, -1);
        send_frame(l, w, a, il, -1);
        kick();
    endtask

    function automatic bit reserved(input logic [3:0] c);
        return c[0] && (c[2:1] != 2'b11);
    endfunction

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int l, w, a;
        bit il;
        logic [3:0] code;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        check(fmt_code == 4'b0000, "R1 code", fmt_code, 4'b0000);
        check(fmt_valid == 1'b0, "R1 valid", {3'b0, fmt_valid}, 4'b0000);
        rst_n = 1'b1;

        // R7: one finished frame is not enough to confirm
        fmt_of(1, l, w, a, il, code);
        send_frame(l, w, a, il, -1);
        send_frame(l, w, a, il, -1);
        check(fmt_valid == 1'b0 && fmt_code == 4'b0000, "R7 single frame",
              {fmt_valid, fmt_code[2:0]}, 4'b0000);
        kick();
        check(fmt_code == code, "R3 1125p 2200", fmt_code, code);
        check(fmt_valid == 1'b1, "R7 valid rises", {3'b0, fmt_valid}, 4'b0001);

        // R3/R4/R5: every table entry
        for (int i = 0; i < 8; i++) begin
            if (i == 1) continue;
            fmt_of(i, l, w, a, il, code);
            establish(l, w, a, il);
            check(fmt_code == code, (i < 4) ? "R3 table" : ((i < 6) ? "R4 table" : "R5 table"), fmt_code, code);
        end

        // R6: unknown progressive and unknown interlaced
        establish(1125/LDIV, 20, 1080/LDIV, 1'b0);
        check(fmt_code == 4'b0111, "R6 unknown progressive", fmt_code, 4'b0111);
        establish(750/LDIV, 1650/WDIV, 26, 1'b1);
        check(fmt_code == 4'b1111, "R6 unknown interlaced", fmt_code, 4'b1111);

        // R7: two frames of a new format, code held until the second is closed
        fmt_of(3, l, w, a, il, code);
        send_frame(l, w, a, il, -1);
        send_frame(l, w, a, il, -1);
        check(fmt_code == 4'b1111, "R7 held before second close", fmt_code, 4'b1111);
        kick();
        check(fmt_code == 4'b0110, "R7 update after match", fmt_code, 4'b0110);

        // R7: alternating frames never agree
        fmt_of(0, l, w, a, il, code);
        send_frame(l, w, a, il, -1);
        fmt_of(2, l, w, a, il, code);
        send_frame(l, w, a, il, -1);
        fmt_of(0, l, w, a, il, code);
        send_frame(l, w, a, il, -1);
        kick();
        check(fmt_code == 4'b0110, "R7 alternating hold", fmt_code, 4'b0110);

        // R8: identical but irregular frames never confirm
        fmt_of(4, l, w, a, il, code);
        for (int k = 0; k < 3; k++) send_frame(l, w, a, il, 5);
        kick();
        check(fmt_code == 4'b0110, "R8 irregular ignored", fmt_code, 4'b0110);
        check(fmt_valid == 1'b1, "R7 valid stays", {3'b0, fmt_valid}, 4'b0001);

        // R2/R9/R10: random rasters against the model
        for (int r = 0; r < 10; r++) begin
            if ($urandom % 3 == 0) begin
                fmt_of(int'($urandom % 8), l, w, a, il, code);
            end else begin
                l = 30 + int'($urandom % 21);
                w = 10 + int'($urandom % 21);
                a = l - 2 - int'($urandom % 3);
                il = bit'($urandom % 2);
            end
            code = model(l, w, a, il);
            establish(l, w, a, il);
            check(fmt_code == code, "R2 random raster", fmt_code, code);
            check(fmt_code[3] == il, "R9 interlace bit", {3'b0, fmt_code[3]}, {3'b0, il});
            check(!reserved(fmt_code), "R6 reserved", fmt_code, code);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule